// File: doc/BRIEF.md
# Pi/4-shifted QPSK symbol mapper

The block turns a stream of two-bit symbols into complex baseband samples for pi/4-shifted quadrature phase shift keying. Each accepted bit pair picks one of four phase increments, all odd multiples of 45 degrees. The increment is added to a phase index that is kept modulo eight. Because every increment is odd, the index alternates between the axis-aligned constellation and the one rotated by 45 degrees. No increment is 180 degrees, so the trajectory from one symbol to the next never passes through the origin.

The output is a signed fixed-point I/Q pair meant for a root-raised-cosine pulse-shaping filter further down the chain. At the nominal 50 Mb/s input rate the block produces 25 Msym/s. Both sides use a valid/ready handshake. The output sits in a register, so an accepted symbol shows up one cycle after it is taken, and it stays in place while the consumer stalls.

Top module: `pi4_qpsk_mapper`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and the phase index is 0 (angle 0). The first accepted symbol therefore steps from angle 0.
- R2: The phase increment is set by sym_bits, with sym_bits[1] as the first bit of the pair: 2'b00 gives +45°, 2'b01 gives +135°, 2'b11 gives −135°, and 2'b10 gives −45°. Phase is counted in 45° units modulo 8.
- R3: For phase index k, out_i = round(AMP·cos(k·45°)) and out_q = round(AMP·sin(k·45°)) as signed W-bit values. With the defaults (AMP = 16384, W = 16) the diagonal magnitude is 11585.
- R4: Successive emitted symbols alternate between the axis set, where exactly one of I and Q is zero, and the diagonal set, where neither is zero.
- R5: No emitted sample is (0,0), and no emitted sample is the exact negation of the sample emitted before it. This means no transition crosses the origin.
- R6: sym_ready = out_ready OR NOT out_valid. A symbol is consumed exactly on a clock edge where sym_valid and sym_ready are both 1.
- R7: While out_valid is 1 and out_ready is 0, out_i, out_q and out_valid hold their values, and offered symbols are not consumed.
- R8: A symbol consumed at a clock edge appears on out_i/out_q with out_valid = 1 right after that same edge, which is one register of latency.
- R9: When out_ready is 1 and no symbol is offered, out_valid drops to 0 after the next edge. The phase index is kept across the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A bit pair is offered |
| sym_ready | output | 1 | The mapper can take a bit pair |
| sym_bits | input | 2 | Bit pair, [1] first |
| out_valid | output | 1 | out_i/out_q hold a symbol |
| out_ready | input | 1 | The consumer takes the sample |
| out_i | output | W | In-phase sample, signed |
| out_q | output | W | Quadrature sample, signed |

## Verification
The bench uses the default width of 16 bits and the default amplitude of 16384. This makes the eight table values, including the rounded diagonal 11585, directly comparable against a cosine computed in the bench. A sequence of bit pairs drives the phase index through all 32 combinations of index and bit pair. Stall, gap and mid-stream reset phases exercise the handshake corners and the return of the phase to angle 0.

// File: rtl/pi4_qpsk_mapper.sv
module pi4_qpsk_mapper #(
  parameter int W   = 16,
  parameter int AMP = 16384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_valid,
  output logic                sym_ready,
  input  logic [1:0]          sym_bits,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_i,
  output logic signed [W-1:0] out_q
);
  localparam logic signed [W-1:0] AX = W'(AMP);
  localparam logic signed [W-1:0] DG = W'((AMP * 46341 + 32768) >>> 16);

  logic [2:0] phase, step, nxt;
  logic       take;

  function automatic logic signed [W-1:0] cos45(input logic [2:0] k);
    case (k)
      3'd0:       cos45 = AX;
      3'd1, 3'd7: cos45 = DG;
      3'd2, 3'd6: cos45 = '0;
      3'd3, 3'd5: cos45 = -DG;
      default:    cos45 = -AX;
    endcase
  endfunction

  always_comb begin
    case (sym_bits)
      2'b00:   step = 3'd1;
      2'b01:   step = 3'd3;
      2'b11:   step = 3'd5;
      default: step = 3'd7;
    endcase
  end

  assign sym_ready = out_ready || !out_valid;
  assign take      = sym_valid && sym_ready;
  assign nxt       = phase + step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (take) begin
      phase     <= nxt;
      out_valid <= 1'b1;
      out_i     <= cos45(nxt);
      out_q     <= cos45(nxt - 3'd2);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  a_r6_no_take_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !sym_ready);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_ready |=> out_valid);

  a_r5_not_origin: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != 0 || out_q != 0));

  a_r5_no_crossing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && take |=> !(out_i == -$past(out_i) && out_q == -$past(out_q)));

  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && take |=> ((out_i == 0 || out_q == 0) != ($past(out_i) == 0 || $past(out_q) == 0)));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready && !sym_valid |=> !out_valid);
endmodule

// File: tb/pi4_qpsk_mapper_bench.sv
module pi4_qpsk_mapper_bench;
  logic clk = 0, rst_n = 0, sym_valid = 0, out_ready = 0;
  logic [1:0] sym_bits = 0;
  logic sym_ready, out_valid;
  logic signed [15:0] out_i, out_q;
  int n_chk = 0, n_bad = 0, ph = 0, cyc = 0;
  logic exp_v = 0;
  int exp_i = 0, exp_q = 0, prev_i = 0, prev_q = 0;
  bit have_prev = 0;

  always #2.5 clk = ~clk;

  pi4_qpsk_mapper u_pi4_qpsk_mapper (.clk, .rst_n, .sym_valid, .sym_ready, .sym_bits,
    .out_valid, .out_ready, .out_i, .out_q);

  function automatic int ref_val(int k, bit is_sin);
    real a = (k * 3.14159265358979 / 4.0) - (is_sin ? 3.14159265358979 / 2.0 : 0.0);
    return int'($floor(16384.0 * $cos(a) + 0.5));
  endfunction

  function automatic int inc(logic [1:0] b);
    case (b)
      2'b00: return 1; 2'b01: return 3; 2'b11: return 5; default: return 7;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_step(bit v, logic [1:0] b, bit rdy);
    bit rdy_exp, tk;
    sym_valid = v; sym_bits = b; out_ready = rdy;
    #1;
    rdy_exp = rdy || !exp_v;
    check(sym_ready == rdy_exp, "R6 sym_ready", sym_ready, rdy_exp);
    tk = v && rdy_exp;
    @(posedge clk); @(negedge clk);
    if (tk) begin
      ph = (ph + inc(b)) % 8;
      exp_v = 1; exp_i = ref_val(ph, 0); exp_q = ref_val(ph, 1);
      check(out_valid == 1, "R8 valid after take", out_valid, 1);
      check(out_i == exp_i, "R2/R3 out_i", out_i, exp_i);
      check(out_q == exp_q, "R2/R3 out_q", out_q, exp_q);
      check(!(out_i == 0 && out_q == 0), "R5 origin", out_i, 1);
      if (have_prev) begin
        check(!(out_i == -prev_i && out_q == -prev_q), "R5 crossing", out_i, -prev_i);
        check(((out_i == 0) || (out_q == 0)) != ((prev_i == 0) || (prev_q == 0)),
              "R4 alternate", out_i, prev_i);
      end
      prev_i = out_i; prev_q = out_q; have_prev = 1;
    end else if (exp_v && !rdy) begin
      check(out_valid == 1 && out_i == exp_i && out_q == exp_q, "R7 hold", out_i, exp_i);
    end else begin
      exp_v = 0; have_prev = 0;
      check(out_valid == 0, "R9 drain", out_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    rst_n = 1;
    for (int n = 0; n < 96; n++) cyc_step(1, 2'((n * 7 + n / 5) & 3), 1);
    for (int n = 0; n < 4; n++) cyc_step(1, 2'(n), 0);
    cyc_step(1, 2'b01, 1);
    cyc_step(0, 2'b00, 1);
    cyc_step(0, 2'b00, 1);
    cyc_step(1, 2'b10, 1);
    for (int n = 0; n < 3; n++) cyc_step(1, 2'b11, (n % 2) == 1);
    rst_n = 0;
    @(posedge clk); @(negedge clk);
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    rst_n = 1; ph = 0; exp_v = 0; have_prev = 0;
    cyc_step(1, 2'b00, 1);
    check(out_i == 11585 && out_q == 11585, "R1 restart at angle 0", out_i, 11585);
    cyc_step(1, 2'b01, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule